// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 24 interrupt request lines from peripherals and external pins and presents a single 3-bit priority level to a processor. Each request is recorded twice. A raw pending register records it whatever the mask says. A status register records it only when the source is unmasked. The level driven to the processor is the highest level found among the set status bits. Most sources have a fixed level. Four sources take their level from a software-written level-control register.

When the processor acknowledges an interrupt, it strobes the acknowledge input together with the level it is taking. One cycle later the block returns a vector number. That number is the programmed vector base ORed with the level. If the base is still zero, the block returns the fixed default vector 15.

A wake request output tells the clock controller that a stopped clock may be restarted. Software reaches five registers through a small synchronous-write, combinational-read bus.

Top module: `irq_prio_ctrl`

## Requirements
- R1: On every clock edge, each bit of `src_i` that is 1 sets the same bit of the pending register (address 0). This happens whether or not the bit is masked.
- R2: A bit of `src_i` that is 1 sets the same bit of the status register (address 2) only when the matching mask bit (address 1) is 0. A mask bit of 1 blocks it.
- R3: Fixed levels by source bit are:
  - bit 20: level 7.
  - bits 7, 12 and 19: level 6.
  - bit 21: level 5.
  - bit 18: level 3.
  - bit 17: level 2.
  - bit 16: level 1.
  - bits 2–6, 8–11 and 22: level 4.
- R4: The level-control register (address 3) resets to 0x6533 and stores only the bits in 0x7777. It sets four programmable levels:
  - bits 14:12 give the level of source bit 0.
  - bits 10:8 give the level of source bit 23.
  - bits 6:4 give the level of source bit 13.
  - bits 2:0 give the level of source bit 1.
- R5: `level_o` is registered. It equals the highest level among the status bits set one cycle earlier. It is 0 when no status bit is set, or when every set bit has level 0.
- R6: The cycle after `ack_i` is high, `vec_valid_o` is 1. In that cycle `vec_o` is the vector base ORed with `ack_level_i`, or 15 when the vector base is zero.
- R7: The vector base (address 4, 8 bits, reset 0) stores write data bits 7:3 and forces bits 2:0 to 0.
- R8: A write to the status address clears, in both the status and the pending registers, each bit that is 1 in both the write data and 0x000F0F00. No other bit changes. A request that is active in the same cycle wins over the clear.
- R9: The mask register resets to 0x00FFFFFF. Only bits in 0x00FF3FFF are writable. Bits 15:14 stay 1 and bits 31:24 stay 0.
- R10: `wake_o` is 1 while any status bit is set. The exception is that a set status bit 8+k does not count when `intx_edge_i[k]` is 1.
- R11: Register addresses are 0 pending, 1 mask, 2 status, 3 level control and 4 vector base. Writes to address 0 are ignored, and addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 24 | Interrupt request lines, one per source bit |
| intx_edge_i | input | 4 | Edge-sensitive flag per external pin source (bits 8 to 11) |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| ack_level_i | input | 3 | Level being acknowledged |
| level_o | output | 3 | Priority level to the processor |
| wake_o | output | 1 | Clock wake request |
| vec_o | output | 8 | Vector number |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
A request present at a clock edge appears in the pending and status registers, and on `wake_o`, right after that edge. `level_o` follows one edge later. A register write takes effect at its edge. A change of level caused by a write therefore shows on `level_o` one further edge on. The vector follows the acknowledge edge by one cycle.

The driver applies each stimulus for exactly one cycle. It then waits the stated number of edges before it queues the expected value. The monitor samples halfway between edges, so every result is read after the edge that produces it has settled.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 24,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [3:0]      intx_edge_i,
  input  logic [2:0]      addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            ack_i,
  input  logic [2:0]      ack_level_i,
  output logic [2:0]      level_o,
  output logic            wake_o,
  output logic [7:0]      vec_o,
  output logic            vec_valid_o
);
  localparam logic [NSRC-1:0] MASK_RST = 24'hFFFFFF;
  localparam logic [NSRC-1:0] MASK_WR  = 24'hFF3FFF;
  localparam logic [NSRC-1:0] EXT_CLR  = 24'h0F0F00;
  localparam logic [15:0]     LVL_RST  = 16'h6533;
  localparam logic [15:0]     LVL_WR   = 16'h7777;
  localparam logic [7:0]      VEC_DFLT = 8'd15;

  logic [NSRC-1:0] pending_q, mask_q, status_q;
  logic [15:0]     lvlctl_q;
  logic [7:0]      vbase_q;
  logic [2:0]      best;
  logic [NSRC-1:0] clr, wake_bits;

  assign clr = (we_i && addr_i == 3'd2) ? (wdata_i[NSRC-1:0] & EXT_CLR) : '0;

  function automatic logic [2:0] lvl_of(input int idx, input logic [15:0] ctl);
    case (idx)
      0:       return ctl[14:12];
      1:       return ctl[2:0];
      13:      return ctl[6:4];
      23:      return ctl[10:8];
      20:      return 3'd7;
      7, 12, 19: return 3'd6;
      21:      return 3'd5;
      18:      return 3'd3;
      17:      return 3'd2;
      16:      return 3'd1;
      default: return 3'd4;
    endcase
  endfunction

  always_comb begin
    best = 3'd0;
    for (int i = 0; i < NSRC; i++)
      if (status_q[i] && lvl_of(i, lvlctl_q) > best) best = lvl_of(i, lvlctl_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q   <= '0;
      status_q    <= '0;
      mask_q      <= MASK_RST;
      lvlctl_q    <= LVL_RST;
      vbase_q     <= '0;
      level_o     <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      pending_q <= (pending_q & ~clr) | src_i;
      status_q  <= (status_q & ~clr) | (src_i & ~mask_q);
      if (we_i && addr_i == 3'd1) mask_q   <= (wdata_i[NSRC-1:0] & MASK_WR) | (mask_q & ~MASK_WR);
      if (we_i && addr_i == 3'd3) lvlctl_q <= wdata_i[15:0] & LVL_WR;
      if (we_i && addr_i == 3'd4) vbase_q  <= {wdata_i[7:3], 3'b000};
      level_o     <= best;
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= (vbase_q == 8'd0) ? VEC_DFLT : (vbase_q | {5'd0, ack_level_i});
    end
  end

  assign wake_bits = {12'd0, ~intx_edge_i, 8'hFF} | ~24'h000F00;
  assign wake_o = |(status_q & wake_bits);

  always_comb begin
    case (addr_i)
      3'd0:    rdata_o = {{(DW-NSRC){1'b0}}, pending_q};
      3'd1:    rdata_o = {{(DW-NSRC){1'b0}}, mask_q};
      3'd2:    rdata_o = {{(DW-NSRC){1'b0}}, status_q};
      3'd3:    rdata_o = {16'd0, lvlctl_q};
      3'd4:    rdata_o = {24'd0, vbase_q};
      default: rdata_o = '0;
    endcase
  end

  p_pend_set_r1: assert property (@(posedge clk) disable iff (rst)
    (src_i != '0) |=> ((pending_q & $past(src_i)) == $past(src_i)));

  p_stat_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
    ((src_i & ~mask_q) != '0) |=> ((status_q & $past(src_i & ~mask_q)) == $past(src_i & ~mask_q)));

  p_top_level_r3: assert property (@(posedge clk) disable iff (rst)
    status_q[20] |=> (level_o == 3'd7));

  p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
    (status_q == '0) |=> (level_o == 3'd0));

  p_dflt_vec_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && vbase_q == 8'd0) |=> (vec_valid_o && vec_o == VEC_DFLT));

  p_wake_src_r10: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (status_q != '0));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic [23:0] src = '0;
  logic [3:0]  edge_sel = '0;
  logic [2:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack = 0;
  logic [2:0]  ack_lvl = '0;
  logic [2:0]  level;
  logic        wake;
  logic [7:0]  vec;
  logic        vec_valid;

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .src_i(src), .intx_edge_i(edge_sel),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .ack_i(ack), .ack_level_i(ack_lvl), .level_o(level), .wake_o(wake),
    .vec_o(vec), .vec_valid_o(vec_valid)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;

  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {29'd0, level};
        2: act = {24'd0, vec};
        3: act = {31'd0, wake};
        default: act = {31'd0, vec_valid};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [2:0] a, input logic [31:0] e, input string r);
    item_t it;
    addr = a;
    #0.2;
    it.kind = kind; it.exp = e; it.req = r;
    q.push_back(it);
    -> sample_ev;
    #0.2;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; src = '0; we = 0; ack = 0;
    cyc(); cyc();
    rst = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    cyc();
    we = 0;
  endtask

  task automatic pulse(input logic [23:0] v);
    src = v;
    cyc();
    src = '0;
  endtask

  task automatic do_ack(input logic [2:0] l);
    ack = 1; ack_lvl = l;
    cyc();
    ack = 0;
  endtask

  initial begin
    cyc();
    do_reset();
    chk(0, 3'd0, 32'h0, "R11 pending reset");
    chk(0, 3'd1, 32'h00FFFFFF, "R9 mask reset");
    chk(0, 3'd2, 32'h0, "R11 status reset");
    chk(0, 3'd3, 32'h6533, "R4 levelctl reset");
    chk(0, 3'd4, 32'h0, "R7 vbase reset");
    chk(1, 3'd0, 32'd0, "R5 level reset");
    chk(3, 3'd0, 32'd0, "R10 wake reset");

    pulse(24'h100000);
    chk(0, 3'd0, 32'h100000, "R1 pending while masked");
    chk(0, 3'd2, 32'h0, "R2 status blocked by mask");
    cyc();
    chk(1, 3'd0, 32'd0, "R2 masked gives no level");

    wr(3'd1, 32'h0);
    chk(0, 3'd1, 32'h0000C000, "R9 mask clear keeps 15:14");
    wr(3'd1, 32'hFFFFFFFF);
    chk(0, 3'd1, 32'h00FFFFFF, "R9 mask set limited");
    wr(3'd0, 32'hFFFFFFFF);
    chk(0, 3'd0, 32'h100000, "R11 pending write ignored");
    chk(0, 3'd5, 32'h0, "R11 unused address");

    do_reset();
    wr(3'd1, 32'h0);
    pulse(24'h010000); cyc();
    chk(1, 3'd0, 32'd1, "R3 bit16 level1");
    pulse(24'h020000); cyc();
    chk(1, 3'd0, 32'd2, "R3 bit17 level2");
    pulse(24'h200000); cyc();
    chk(1, 3'd0, 32'd5, "R3 bit21 level5");
    pulse(24'h100000);
    chk(3, 3'd0, 32'd1, "R10 wake on status");
    cyc();
    chk(1, 3'd0, 32'd7, "R3 bit20 level7");
    wr(3'd2, 32'hFFFFFFFF);
    chk(0, 3'd2, 32'h300000, "R8 status ext clear");
    chk(0, 3'd0, 32'h300000, "R8 pending ext clear");
    cyc();
    chk(1, 3'd0, 32'd7, "R5 level after clear");

    do_reset();
    wr(3'd1, 32'h0);
    pulse(24'h000001); cyc();
    chk(1, 3'd0, 32'd6, "R4 bit0 reset level 6");
    wr(3'd3, 32'hF123);
    chk(0, 3'd3, 32'h7123, "R4 levelctl write mask");
    cyc();
    chk(1, 3'd0, 32'd7, "R4 bit0 level 7");
    wr(3'd3, 32'h2000); cyc();
    chk(1, 3'd0, 32'd2, "R4 bit0 level 2");
    pulse(24'h800000); cyc();
    chk(1, 3'd0, 32'd2, "R4 bit23 level 0");
    wr(3'd3, 32'h2500); cyc();
    chk(1, 3'd0, 32'd5, "R4 bit23 level 5");
    pulse(24'h002000);
    wr(3'd3, 32'h2570); cyc();
    chk(1, 3'd0, 32'd7, "R4 bit13 level 7");
    wr(3'd3, 32'h0003); cyc();
    chk(1, 3'd0, 32'd0, "R5 set bits all level 0");
    pulse(24'h000002); cyc();
    chk(1, 3'd0, 32'd3, "R4 bit1 level 3");

    do_reset();
    do_ack(3'd4);
    chk(4, 3'd0, 32'd1, "R6 vec valid");
    chk(2, 3'd0, 32'd15, "R6 default vector");
    cyc();
    chk(4, 3'd0, 32'd0, "R6 valid one cycle");
    wr(3'd4, 32'hFF);
    chk(0, 3'd4, 32'hF8, "R7 vbase low bits dropped");
    do_ack(3'd5);
    chk(2, 3'd0, 32'hFD, "R6 base or level");

    do_reset();
    wr(3'd1, 32'h000001);
    pulse(24'h001005); cyc();
    chk(0, 3'd0, 32'h001005, "R1 pending all");
    chk(0, 3'd2, 32'h001004, "R2 masked bit0 absent");
    chk(1, 3'd0, 32'd6, "R3 bit12 level6");

    do_reset();
    wr(3'd1, 32'h0);
    edge_sel = 4'b0001;
    pulse(24'h000100);
    chk(3, 3'd0, 32'd0, "R10 edge INT0 no wake");
    cyc();
    chk(1, 3'd0, 32'd4, "R3 bit8 level4");
    pulse(24'h000200);
    chk(3, 3'd0, 32'd1, "R10 level INT1 wakes");
    wr(3'd2, 32'h00000300);
    chk(3, 3'd0, 32'd0, "R8 clear drops wake");
    chk(0, 3'd0, 32'h0, "R8 pending cleared");
    cyc();
    chk(1, 3'd0, 32'd0, "R5 level back to 0");

    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule